// File: doc/BRIEF.md
# Pre/post-trigger circular capture controller

This block runs sample capture for a digital oscilloscope front end. Once armed, every accepted sample strobe writes the incoming ADC word into a circular buffer. The write address wraps at the end of the buffer, so the most recent history before a trigger is always kept. A rising edge on the trigger input counts only after the buffer holds enough history. The qualifying edge records the current write address and starts a post-trigger countdown. That countdown decrements on accepted samples, not on system clocks. When it runs out, sampling stops. The buffer is then frozen for random-access reads until software arms the block again.

The usable record is set a few entries shorter than the physical buffer. The spare entries give slack when the trigger position is uncertain. A reader uses the latched trigger address to unroll the wrapped record: the pre-trigger samples sit just below that address, and the post-trigger samples start at it.

Top module: `trig_capture`

## Requirements
- R1: During and directly after reset the block is stopped: running_o, pretrig_ok_o, trig_evt_o and done_evt_o are 0 and trig_addr_o is 0.
- R2: arm_i is accepted only while stopped. Acceptance sets running_o on the next cycle, loads post_len_i, sets the write address to 0 and clears the history count. arm_i while running has no effect.
- R3: While running, each cycle with smp_stb_i high writes smp_data_i at the current write address. The address then increments modulo 2^ADDR_W.
- R4: pretrig_ok_o is 1 once at least 2^ADDR_W - SLACK samples have been written since the last arm. A trigger edge seen while it is 0 is ignored.
- R5: A qualifying 0-to-1 change on trig_i while running and untriggered gives a one-cycle trig_evt_o pulse on the next cycle. trig_addr_o then holds the write address of that cycle, which is the address of the first post-trigger sample.
- R6: After the trigger, capture writes exactly post_len_i + 1 samples, counting a sample written in the trigger cycle. With a post length of 0, only that first sample is written.
- R7: The final write is followed on the next cycle by a one-cycle done_evt_o pulse, and running_o is 0 from that cycle on.
- R8: Once triggered, further trigger edges produce no trig_evt_o and leave trig_addr_o unchanged until re-armed.
- R9: While stopped, smp_stb_i writes nothing. rd_data_o returns the word at rd_addr_i one cycle after the address is presented; a same-cycle write is not yet visible.
- R10: Only a 0-to-1 change of trig_i triggers. A level held high from before history is complete never triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a new capture (only accepted when stopped) |
| post_len_i | input | CNT_W | Post-trigger samples beyond the trigger sample |
| smp_stb_i | input | 1 | Sample-rate strobe |
| smp_data_i | input | DATA_W | ADC sample word |
| trig_i | input | 1 | Trigger comparator level |
| rd_addr_i | input | ADDR_W | Buffer read address |
| running_o | output | 1 | Capture in progress |
| pretrig_ok_o | output | 1 | Enough pre-trigger history held |
| trig_evt_o | output | 1 | One-cycle trigger-accepted event |
| done_evt_o | output | 1 | One-cycle capture-complete event |
| trig_addr_o | output | ADDR_W | Write address latched at trigger |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
The assertions check the following on every cycle:
- No write happens while the block is stopped.
- Capture leaves the running state only through the done event.
- Both events are single-cycle pulses.
- A trigger event is always preceded by complete history.
- The trigger address moves only with a trigger event.

Some behaviour can only be shown by the bench scenarios, which compare against a model. These are the exact count of post-trigger samples, the wrapped buffer contents read back after a stop, and the fact that early or held trigger levels and arms during a run are ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_STOP = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned PRE_MIN = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              pre_ok_o
);
  localparam int unsigned FILL_W = $clog2(PRE_MIN + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PRE_MIN);

  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      ptr_o  <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      ptr_o <= ptr_o + ADDR_W'(1);
      if (fill_q != FILL_MAX) fill_q <= fill_q + FILL_W'(1);
    end
  end

  assign pre_ok_o = (fill_q == FILL_MAX);
endmodule

// File: rtl/cap_post_cnt.sv
module cap_post_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cap_trig_qual.sv
module cap_trig_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic waiting_i,
  input  logic pre_ok_i,
  output logic hit_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  // edge only; held level never re-qualifies
  assign hit_o = trig_i & ~trig_q & waiting_i & pre_ok_i;
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import cap_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SLACK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  post_len_i,
  input  logic              smp_stb_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              running_o,
  output logic              pretrig_ok_o,
  output logic              trig_evt_o,
  output logic              done_evt_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned PRE_MIN = DEPTH - SLACK;

  cap_state_e        state_q, state_d;
  logic              arm_ok, running, wr_en, hit, active, last, dec, cnt_zero, pre_ok;
  logic [ADDR_W-1:0] wr_ptr;

  assign running = (state_q != CAP_STOP);
  assign arm_ok  = (state_q == CAP_STOP) & arm_i;
  assign wr_en   = running & smp_stb_i;
  assign active  = (state_q == CAP_POST) | hit;
  assign last    = wr_en & active & cnt_zero;
  assign dec     = wr_en & active & ~cnt_zero;

  cap_wr_ptr #(.ADDR_W(ADDR_W), .PRE_MIN(PRE_MIN)) i_wr_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (arm_ok),
    .adv_i    (wr_en),
    .ptr_o    (wr_ptr),
    .pre_ok_o (pre_ok)
  );

  cap_post_cnt #(.CNT_W(CNT_W)) i_post_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (arm_ok),
    .load_val_i (post_len_i),
    .dec_i      (dec),
    .zero_o     (cnt_zero)
  );

  cap_trig_qual i_trig_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .waiting_i (state_q == CAP_PRE),
    .pre_ok_i  (pre_ok),
    .hit_o     (hit)
  );

  cap_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (smp_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CAP_STOP: if (arm_i) state_d = CAP_PRE;
      CAP_PRE: begin
        if (last)     state_d = CAP_STOP;
        else if (hit) state_d = CAP_POST;
      end
      CAP_POST: if (last) state_d = CAP_STOP;
      default:  state_d = CAP_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CAP_STOP;
      trig_evt_o  <= 1'b0;
      done_evt_o  <= 1'b0;
      trig_addr_o <= '0;
    end else begin
      state_q    <= state_d;
      trig_evt_o <= hit;
      done_evt_o <= last;
      if (hit) trig_addr_o <= wr_ptr;
    end
  end

  assign running_o    = running;
  assign pretrig_ok_o = pre_ok;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              running_i,
  input logic              pre_ok_i,
  input logic              trig_evt_i,
  input logic              done_evt_i,
  input logic [ADDR_W-1:0] trig_addr_i,
  input logic              wr_en_i
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r9_no_write_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> !wr_en_i);

  a_r2_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> (running_i || done_evt_i));

  a_r7_done_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i |-> !running_i);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i |=> !done_evt_i);

  a_r5_trig_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt_i |=> !trig_evt_i);

  a_r4_trig_needs_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && trig_evt_i) |-> $past(pre_ok_i));

  a_r8_taddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !trig_evt_i) |-> $stable(trig_addr_i));
endmodule

bind trig_capture trig_capture_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .running_i   (running_o),
  .pre_ok_i    (pretrig_ok_o),
  .trig_evt_i  (trig_evt_o),
  .done_evt_i  (done_evt_o),
  .trig_addr_i (trig_addr_o),
  .wr_en_i     (wr_en)
);

// File: tb/test_trig_capture.sv
module test_trig_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 12;
  localparam int ADDR_W  = 6;
  localparam int CNT_W   = 6;
  localparam int SLACK   = 4;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PRE_MIN = DEPTH - SLACK;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic arm_i = 0, smp_stb_i = 0, trig_i = 0;
  logic [CNT_W-1:0]  post_len_i = '0;
  logic [DATA_W-1:0] smp_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic running_o, pretrig_ok_o, trig_evt_o, done_evt_o;
  logic [ADDR_W-1:0] trig_addr_o;
  logic [DATA_W-1:0] rd_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLACK(SLACK)) i_trig_capture (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .post_len_i(post_len_i),
    .smp_stb_i(smp_stb_i), .smp_data_i(smp_data_i), .trig_i(trig_i), .rd_addr_i(rd_addr_i),
    .running_o(running_o), .pretrig_ok_o(pretrig_ok_o), .trig_evt_o(trig_evt_o),
    .done_evt_o(done_evt_o), .trig_addr_o(trig_addr_o), .rd_data_o(rd_data_o));

  int n_chk = 0, n_err = 0;
  int n_tevt = 0, n_devt = 0;

  // reference model
  int m_state = 0, m_ptr = 0, m_fill = 0, m_cnt = 0;
  logic m_tprev = 0;
  logic [DATA_W-1:0] m_mem [DEPTH];
  bit m_val [DEPTH];
  int e_taddr = 0;

  function automatic bool_exp(input int v);
    return v != 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic arm, input int plen, input logic stb,
                     input logic [DATA_W-1:0] d, input logic trg, input int ra);
    bit hit, e_tevt, e_devt, rv;
    logic [DATA_W-1:0] rexp;
    arm_i = arm; post_len_i = CNT_W'(plen); smp_stb_i = stb;
    smp_data_i = d; trig_i = trg; rd_addr_i = ADDR_W'(ra);
    rv = m_val[ra]; rexp = m_mem[ra];
    e_tevt = 0; e_devt = 0;
    if (m_state == 0) begin
      if (arm) begin m_state = 1; m_ptr = 0; m_fill = 0; m_cnt = plen; end
    end else begin
      hit = trg && !m_tprev && m_state == 1 && m_fill >= PRE_MIN;
      if (hit) begin e_tevt = 1; e_taddr = m_ptr; m_state = 2; end
      if (stb) begin
        m_mem[m_ptr] = d; m_val[m_ptr] = 1;
        if (m_state == 2) begin
          if (m_cnt == 0) begin m_state = 0; e_devt = 1; end
          else m_cnt--;
        end
        m_ptr = (m_ptr + 1) % DEPTH;
        if (m_fill < PRE_MIN) m_fill++;
      end
    end
    m_tprev = trg;
    @(posedge clk); @(negedge clk);
    if (trig_evt_o) n_tevt++;
    if (done_evt_o) n_devt++;
    check("R2 running", int'(running_o), int'(m_state != 0));
    check("R4 pretrig_ok", int'(pretrig_ok_o), int'(m_fill >= PRE_MIN));
    check("R5 trig_evt", int'(trig_evt_o), int'(e_tevt));
    check("R7 done_evt", int'(done_evt_o), int'(e_devt));
    check("R8 trig_addr", int'(trig_addr_o), e_taddr);
    if (rv) check("R3 rd_data", int'(rd_data_o), int'(rexp));
  endtask

  task automatic fill_hist(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, DATA_W'($urandom), 0, $urandom % DEPTH);
  endtask

  task automatic readback();
    // strobes while stopped must not write (R9)
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 1, DATA_W'($urandom), 0, a);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int t0, plen;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 running", int'(running_o), 0);
    check("R1 pretrig_ok", int'(pretrig_ok_o), 0);
    check("R1 trig_evt", int'(trig_evt_o), 0);
    check("R1 done_evt", int'(done_evt_o), 0);
    check("R1 trig_addr", int'(trig_addr_o), 0);
    rst_ni = 1'b1;
    cyc(0, 0, 1, 12'h123, 0, 0);   // stopped: no write
    check("R1 idle after reset", int'(running_o), 0);

    // R4: early trigger ignored, then qualified trigger with post=3
    cyc(1, 3, 0, 0, 0, 0);
    fill_hist(10);
    cyc(0, 0, 1, 12'h0AA, 1, 0);
    fill_hist(2);
    cyc(0, 0, 1, 12'h0BB, 0, 0);
    check("R4 early trigger ignored", n_tevt, 0);
    fill_hist(PRE_MIN);
    n_tevt = 0;
    cyc(0, 0, 1, 12'h5A5, 1, 0);
    check("R5 qualified trigger", n_tevt, 1);
    for (int i = 0; i < 10 && running_o; i++) cyc(0, 0, 1, DATA_W'($urandom), (i % 2) == 0, 0);
    check("R8 single trigger", n_tevt, 1);
    readback();

    // R10: level held high from before history complete never triggers
    cyc(1, 2, 0, 0, 1, 0);
    n_tevt = 0;
    for (int i = 0; i < PRE_MIN + 20; i++) cyc(0, 0, 1, DATA_W'($urandom), 1, 0);
    check("R10 held level", n_tevt, 0);
    cyc(0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 2, 1, 0);  // edge without strobe
    check("R10 edge triggers", n_tevt, 1);

    // R6: exact sample count, post=2 but trigger cycle had no strobe -> 3 strobes
    t0 = 0; n_devt = 0;
    while (running_o && t0 < 20) begin cyc(0, 0, 1, DATA_W'($urandom), 1, 0); t0++; end
    check("R6 samples after trigger (post=2)", t0, 3);
    readback();

    // R6: post=0 with strobe on trigger cycle
    cyc(1, 0, 0, 0, 0, 0);
    fill_hist(PRE_MIN + 7);
    n_devt = 0;
    cyc(0, 0, 1, 12'h777, 1, 0);
    check("R6 post zero stops on trigger sample", n_devt, 1);
    check("R6 post zero trig addr", int'(trig_addr_o), (PRE_MIN + 7) % DEPTH);
    readback();

    // R6: post=5, strobe each cycle from trigger: 6 samples
    cyc(1, 5, 0, 0, 0, 0);
    fill_hist(PRE_MIN + 30);
    t0 = 0;
    cyc(0, 0, 1, DATA_W'($urandom), 1, 0); t0++;
    while (running_o && t0 < 30) begin cyc(0, 0, 1, DATA_W'($urandom), 0, 0); t0++; end
    check("R6 post five", t0, 6);
    readback();

    // constrained random runs, including ignored arms (R2)
    for (int run = 0; run < 12; run++) begin
      int rate, n;
      logic trg;
      plen = $urandom % 24;
      rate = 40 + ($urandom % 61);
      cyc(1, plen, 0, 0, 0, 0);
      n = 0; trg = 0;
      while (m_state != 0) begin
        bit s, a;
        s = ($urandom % 100) < rate;
        if (n > 300) begin s = 1; trg = (n % 4) < 2; end
        else if (($urandom % 100) < 6) trg = ~trg;
        a = ($urandom % 100) < 3;
        cyc(a, $urandom % 24, s, DATA_W'($urandom), trg, $urandom % DEPTH);
        n++;
      end
      readback();
    end

    summary();
    $finish;
  end
endmodule